// File: doc/BRIEF.md
# Clock-Crossing Elastic Buffer with Skip Removal and Filler Insertion

This block hands received 8b/10b-decoded symbols from the clock recovered out of the incoming bit stream over to the locally generated clock that runs the protocol engine. The two clocks share a nominal frequency but drift apart by the sum of both oscillator tolerances. For example, ten parts per million on each end of a 1 Gbit/s link leaves some twenty thousand surplus bits every second, so a plain dual-clock FIFO would overflow sooner or later.

Rate matching works in both directions. On the recovered-clock side, skip symbols (the K28.1 code: byte 0x3C with the K flag raised) are thrown away before they reach storage. This lets the faster writer make room for itself. On the local side the reader produces exactly one symbol per clock. When storage holds nothing, it emits a K28.1 filler marked as injected, so the consumer never sees a gap and simply discards skips. The read and write positions cross between the clock domains as Gray codes through two-stage synchronizers.

Top module: `elastic_skip_buffer`

## Requirements
- R1: While reset is held, the read port shows byte 0x3C, K flag 1 and injected flag 1, and both the overflow and underflow flags read 0.
- R2: Every written symbol that is not a skip appears on the read port exactly once, in write order, with its byte and K flag unchanged and the injected flag 0.
- R3: A skip symbol (byte 0x3C with K flag 1) is discarded on write. Byte 0x3C with K flag 0, and K symbols with other byte values, are stored like data.
- R4: In every read-clock cycle in which the storage is seen as empty, the read port outputs a filler: byte 0x3C, K flag 1, injected flag 1.
- R5: The underflow flag goes to 1 in the first cycle a filler is injected after reset, and stays at 1 until the next read-side reset.
- R6: The storage holds DEPTH symbols. A non-skip write that arrives while it is full is dropped, and the overflow flag goes to 1 and stays at 1 until the next write-side reset. The DEPTH symbols already stored are still delivered in order.
- R7: A skip symbol that arrives while the storage is full does not set the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered clock for the write side |
| wr_rst_n | input | 1 | Active-low reset, write side |
| wr_valid | input | 1 | A symbol is offered this cycle |
| wr_data | input | 8 | Symbol byte |
| wr_is_k | input | 1 | Symbol is a control (K) code |
| wr_overflow | output | 1 | Sticky flag: a non-skip symbol was dropped because storage was full |
| rd_clk | input | 1 | Local clock for the read side |
| rd_rst_n | input | 1 | Active-low reset, read side |
| rd_data | output | 8 | Output symbol byte |
| rd_is_k | output | 1 | Output symbol is a control (K) code |
| rd_filler | output | 1 | Output symbol is an injected K28.1 filler |
| rd_underflow | output | 1 | Sticky flag: at least one filler has been injected |

## Verification
The bench builds the buffer with DEPTH set to 8, down from the default of 16. This makes the full condition reachable with a handful of writes, so the overflow drop and the rule that a skip arriving at full is harmless can both be checked within a few cycles. The bench halts the local clock to freeze the reader. Because the recovered clock runs slightly slower than the local one, the buffer drains faster than it fills during the streaming test, which keeps filler insertion happening between stored symbols.

// File: rtl/esb_pkg.sv
package esb_pkg;

    localparam logic [7:0] SKIP_CODE = 8'h3C;

    typedef struct packed {
        logic       is_k;
        logic [7:0] code;
    } sym_t;

    function automatic logic is_skip(input sym_t s);
        return s.is_k && (s.code == SKIP_CODE);
    endfunction

endpackage

// File: rtl/esb_gray_sync.sv
module esb_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.s2;
endmodule

// File: rtl/esb_wr_ctrl.sv
module esb_wr_ctrl
    import esb_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  sym_t          wr_sym,
    input  logic [AW:0]   rd_gray_s,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic [AW:0]   wr_gray,
    output logic          overflow
);
    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
        logic        ovf;
    } wst_t;

    wst_t        st_d, st_q;
    logic        accept;
    logic        full;
    logic [AW:0] bin_inc;

    always_comb begin
        accept  = wr_valid && !is_skip(wr_sym);
        full    = (st_q.gray == {~rd_gray_s[AW:AW-1], rd_gray_s[AW-2:0]});
        bin_inc = st_q.bin + 1'b1;
        we      = accept && !full;
        st_d    = st_q;
        if (we) begin
            st_d.bin  = bin_inc;
            st_d.gray = bin_inc ^ (bin_inc >> 1);
        end
        if (accept && full) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr    = st_q.bin[AW-1:0];
    assign wr_gray  = st_q.gray;
    assign overflow = st_q.ovf;

    // R6
    wr_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);
    // R3
    skip_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && is_skip(wr_sym)) |=> $stable(st_q.bin));
    // R6
    full_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && full) |=> ($stable(st_q.bin) && st_q.ovf));
    // R2
    wr_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(st_q.gray ^ $past(st_q.gray)) <= 1));
endmodule

// File: rtl/esb_rd_ctrl.sv
module esb_rd_ctrl
    import esb_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sym_t          rd_entry,
    input  logic [AW:0]   wr_gray_s,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rd_gray,
    output sym_t          out_sym,
    output logic          out_filler,
    output logic          underflow
);
    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
        sym_t        sym;
        logic        filler;
        logic        udf;
    } rst_t;

    localparam rst_t RST_VAL = '{
        bin:    '0,
        gray:   '0,
        sym:    '{is_k: 1'b1, code: SKIP_CODE},
        filler: 1'b1,
        udf:    1'b0
    };

    rst_t        st_d, st_q;
    logic        empty;
    logic [AW:0] bin_inc;

    always_comb begin
        empty   = (st_q.gray == wr_gray_s);
        bin_inc = st_q.bin + 1'b1;
        st_d    = st_q;
        if (empty) begin
            st_d.sym.is_k = 1'b1;
            st_d.sym.code = SKIP_CODE;
            st_d.filler   = 1'b1;
            st_d.udf      = 1'b1;
        end else begin
            st_d.sym    = rd_entry;
            st_d.filler = 1'b0;
            st_d.bin    = bin_inc;
            st_d.gray   = bin_inc ^ (bin_inc >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign raddr      = st_q.bin[AW-1:0];
    assign rd_gray    = st_q.gray;
    assign out_sym    = st_q.sym;
    assign out_filler = st_q.filler;
    assign underflow  = st_q.udf;

    // R4
    fill_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> (st_q.filler && st_q.sym.is_k && st_q.sym.code == SKIP_CODE));
    // R2
    drain_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |=> !st_q.filler);
    // R5
    udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.udf |=> st_q.udf);
    // R2
    rd_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(st_q.gray ^ $past(st_q.gray)) <= 1));
endmodule

// File: rtl/elastic_skip_buffer.sv
module elastic_skip_buffer
    import esb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       wr_clk,
    input  logic       wr_rst_n,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       wr_is_k,
    output logic       wr_overflow,
    input  logic       rd_clk,
    input  logic       rd_rst_n,
    output logic [7:0] rd_data,
    output logic       rd_is_k,
    output logic       rd_filler,
    output logic       rd_underflow
);
    localparam int AW = $clog2(DEPTH);

    sym_t          in_sym;
    sym_t          entry;
    sym_t          out_sym;
    logic [AW-1:0] waddr, raddr;
    logic          we;
    logic [AW:0]   wr_gray, rd_gray;
    logic [AW:0]   wr_gray_in_rd, rd_gray_in_wr;
    sym_t          mem_q [DEPTH];

    assign in_sym = '{is_k: wr_is_k, code: wr_data};

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= in_sym;
    end

    assign entry = mem_q[raddr];

    esb_wr_ctrl #(.AW(AW)) u_wr (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .wr_valid  (wr_valid),
        .wr_sym    (in_sym),
        .rd_gray_s (rd_gray_in_wr),
        .waddr     (waddr),
        .we        (we),
        .wr_gray   (wr_gray),
        .overflow  (wr_overflow)
    );

    esb_gray_sync #(.W(AW + 1)) u_sync_r2w (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .async_in (rd_gray),
        .sync_out (rd_gray_in_wr)
    );

    esb_gray_sync #(.W(AW + 1)) u_sync_w2r (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .async_in (wr_gray),
        .sync_out (wr_gray_in_rd)
    );

    esb_rd_ctrl #(.AW(AW)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .rd_entry   (entry),
        .wr_gray_s  (wr_gray_in_rd),
        .raddr      (raddr),
        .rd_gray    (rd_gray),
        .out_sym    (out_sym),
        .out_filler (rd_filler),
        .underflow  (rd_underflow)
    );

    assign rd_data = out_sym.code;
    assign rd_is_k = out_sym.is_k;
endmodule

// File: tb/elastic_skip_buffer_tb.sv
`timescale 1ns/1ps
module elastic_skip_buffer_tb;
    localparam int DEPTH = 8;
    localparam int NVEC  = 12;
    // each entry: {K flag, byte}
    localparam logic [8:0] VEC [NVEC] = '{
        9'h041, 9'h13C, 9'h03C, 9'h1BC, 9'h000, 9'h13C,
        9'h13C, 9'h0FF, 9'h17C, 9'h055, 9'h1FB, 9'h0AA
    };

    logic       wr_clk = 1'b0, rd_clk = 1'b0, rd_run = 1'b1;
    logic       wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic       wr_valid = 1'b0, wr_is_k = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_overflow, rd_is_k, rd_filler, rd_underflow;
    logic [7:0] rd_data;

    int total = 0, bad = 0, bad_fill = 0;
    bit mon_on = 1'b0, done = 1'b0;
    logic [8:0] got [$];
    logic [8:0] exp_q [$];

    always #4.1 wr_clk = ~wr_clk;
    always begin
        #4;
        if (rd_run) rd_clk = ~rd_clk;
    end

    elastic_skip_buffer #(.DEPTH(DEPTH)) u_dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_is_k(wr_is_k), .wr_overflow(wr_overflow),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_data(rd_data),
        .rd_is_k(rd_is_k), .rd_filler(rd_filler), .rd_underflow(rd_underflow)
    );

    always @(negedge rd_clk) begin
        if (rd_rst_n && mon_on) begin
            if (!rd_filler) got.push_back({rd_is_k, rd_data});
            else if (!(rd_is_k && rd_data == 8'h3C)) bad_fill++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [8:0] s);
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_is_k  = s[8];
        wr_data  = s[7:0];
    endtask

    task automatic idle_wr();
        @(negedge wr_clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge rd_clk);
    endtask

    task automatic do_reset();
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        #50;
        // R1: reset state
        chk(rd_data == 8'h3C, "R1", rd_data, 8'h3C);
        chk(rd_is_k && rd_filler, "R1", {rd_is_k, rd_filler}, 2'b11);
        chk(!wr_overflow, "R1", wr_overflow, 0);
        chk(!rd_underflow, "R1/R5", rd_underflow, 0);
        @(negedge wr_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        rd_wait(6);
        // R5: fillers have been injected since reset
        chk(rd_underflow, "R5", rd_underflow, 1);
        // R4: empty buffer yields filler
        chk(rd_filler && rd_is_k && rd_data == 8'h3C, "R4",
            {rd_filler, rd_is_k, rd_data}, {2'b11, 8'h3C});

        // table walk: skips dropped (R3), rest delivered in order (R2)
        got.delete();
        exp_q.delete();
        mon_on = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            put(VEC[i]);
            if (!(VEC[i][8] && VEC[i][7:0] == 8'h3C)) exp_q.push_back(VEC[i]);
        end
        idle_wr();
        rd_wait(20);
        chk(got.size() == exp_q.size(), "R3", got.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            chk(got[i] == exp_q[i], "R2", got[i], exp_q[i]);
        chk(!wr_overflow, "R2", wr_overflow, 0);

        // fill with reader frozen
        rd_run = 1'b0;
        #40;
        got.delete();
        for (int i = 0; i < DEPTH; i++) put(9'h010 + 9'(i));
        for (int i = 0; i < 3; i++) put(9'h13C);
        idle_wr();
        idle_wr();
        // R7: skips at full leave overflow clear
        chk(!wr_overflow, "R7", wr_overflow, 0);
        put(9'h099);
        idle_wr();
        idle_wr();
        // R6: dropped write sets overflow
        chk(wr_overflow, "R6", wr_overflow, 1);
        rd_run = 1'b1;
        rd_wait(30);
        chk(got.size() == DEPTH, "R6", got.size(), DEPTH);
        for (int i = 0; i < DEPTH && i < got.size(); i++)
            chk(got[i] == 9'h010 + 9'(i), "R6", got[i], 9'h010 + 9'(i));
        chk(wr_overflow, "R6", wr_overflow, 1);
        // R4/R5 after drain
        chk(rd_filler && rd_is_k && rd_data == 8'h3C, "R4",
            {rd_filler, rd_is_k, rd_data}, {2'b11, 8'h3C});
        chk(rd_underflow, "R5", rd_underflow, 1);
        mon_on = 1'b0;
        chk(bad_fill == 0, "R4", bad_fill, 0);

        // second reset clears sticky flags
        do_reset();
        rd_wait(3);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule